// File: doc/BRIEF.md
# Error-State-Aware Message Arbiter

This block picks a single transmitter for a shared arbitration window among a parameterised set of bus nodes (three by default). Each node offers a valid flag, a message identifier, a remote-request bit and a two-bit error state. When the window opens, every node that is able to send is ranked, and the winning node index is captured. The capture is held for as long as the window stays open. When nobody can send, a no-winner flag marks the window as idle.

Ranking uses three tiers, applied in order:

1. Error state: a node in the error-active state beats a node in the error-passive state.
2. Frame kind: a remote-request frame beats a data frame.
3. Identifier: the numerically lower identifier wins.

If two nodes are still equal after all three tiers, the lower node index wins. A node whose error state says it is off the bus never takes part. The block does not count errors and does not move frames; it only decides who transmits.

Top module: `msgarb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `grant_vld`, `no_winner` and `grant_idx` are all 0.
- R2: Among contenders of equal error tier and equal frame kind, the node with the numerically lowest identifier wins.
- R3: A node is not a contender if its `node_vld` bit is 0, or if its identifier is all ones (value 7 at the default width), which means it has nothing to send.
- R4: If no node is a contender when the window opens, `no_winner` is 1 and `grant_vld` is 0. `grant_vld` and `no_winner` are never both 1.
- R5: Within one error tier, a contender with its remote-request bit at 1 beats every contender with that bit at 0, whatever their identifiers.
- R6: A contender with error state 0 (active) beats every contender with error state 1 (passive), whatever their frame kind or identifier.
- R7: A node with error state 2 or 3 (off the bus) is never granted, whatever else it presents.
- R8: Two contenders with equal tier, equal frame kind and equal identifier resolve to the lower node index.
- R9: The decision is taken from the inputs present at the first clock edge where `win_open` is 1. The outputs then stay unchanged while `win_open` remains 1, whatever the node inputs do.
- R10: After any clock edge at which `win_open` is 0, `grant_vld` and `no_winner` are 0 and `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| win_open | input | 1 | Arbitration window is open |
| node_vld | input | N | Per-node request valid |
| node_id | input | N*IDW | Per-node message identifier, node 0 in the low bits |
| node_rtr | input | N | Per-node remote-request bit (1 = request frame) |
| node_err | input | N*2 | Per-node error state: 0 active, 1 passive, 2 or 3 off the bus |
| grant_vld | output | 1 | A winner was chosen for the open window |
| grant_idx | output | $clog2(N) | Index of the winning node |
| no_winner | output | 1 | The window is open and no node could send |

## Verification
The selection logic and the hold register act on the same edge. The contenders may change in the very cycle after a capture, and the window may close while they are changing. The bench therefore replaces the contender set on the edge right after every capture, choosing a set that would pick a different node, and then closes the window. It expects the first decision to survive the change and the outputs to clear after the close. A near-exhaustive sweep over three nodes also crosses all the tier rules with the tie rule in one decision, and an arithmetic ranking score in the bench judges every outcome.

// File: rtl/msgarb_pkg.sv
package msgarb_pkg;

   typedef enum logic [1:0] {
      ERR_ACTIVE  = 2'd0,
      ERR_PASSIVE = 2'd1,
      ERR_OFF     = 2'd2,
      ERR_OFF_ALT = 2'd3
   } err_state_e;

   // Both upper codes mean the node is off the bus.
   function automatic logic err_is_off(input logic [1:0] st);
      return st[1];
   endfunction

   function automatic logic err_is_passive(input logic [1:0] st);
      return st == ERR_PASSIVE;
   endfunction

endpackage

// File: rtl/msgarb_elig.sv
module msgarb_elig
   import msgarb_pkg::*;
#(
   parameter int IDW = 3,
   localparam int KW = IDW + 2
) (
   input  logic           vld,
   input  logic [IDW-1:0] id,
   input  logic           rtr,
   input  logic [1:0]     err,
   output logic           elig,
   output logic [KW-1:0]  key
);
   localparam logic [IDW-1:0] IDLE_ID = '1;

   // Smaller key ranks higher: passive bit, then data bit, then identifier.
   always_comb begin
      elig = vld && (id != IDLE_ID) && !err_is_off(err);
      key  = {err_is_passive(err), !rtr, id};
   end
endmodule

// File: rtl/msgarb_pick.sv
module msgarb_pick #(
   parameter int N    = 3,
   parameter int KW   = 5,
   parameter int IDXW = 2
) (
   input  logic [N-1:0]    elig,
   input  logic [N*KW-1:0] keys,
   output logic            any,
   output logic [IDXW-1:0] idx
);
   logic [KW-1:0]   best_key [N];
   logic [IDXW-1:0] best_idx [N];
   logic            best_any [N];

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_stage
         if (i == 0) begin : g_first
            assign best_key[0] = keys[KW-1:0];
            assign best_idx[0] = '0;
            assign best_any[0] = elig[0];
         end else begin : g_next
            logic take;
            // Strict compare keeps the earlier (lower) index on a tie.
            assign take = elig[i] &&
                          (!best_any[i-1] || (keys[i*KW +: KW] < best_key[i-1]));
            assign best_key[i] = take ? keys[i*KW +: KW] : best_key[i-1];
            assign best_idx[i] = take ? IDXW'(i) : best_idx[i-1];
            assign best_any[i] = best_any[i-1] | elig[i];
         end
      end
   endgenerate

   assign any = best_any[N-1];
   assign idx = best_idx[N-1];
endmodule

// File: rtl/msgarb_hold.sv
module msgarb_hold #(
   parameter int IDXW = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            win_open,
   input  logic            any,
   input  logic [IDXW-1:0] idx_in,
   output logic            grant_vld,
   output logic [IDXW-1:0] grant_idx,
   output logic            no_winner
);
   logic taken_q;

   always_ff @(posedge clk) begin
      if (rst || !win_open) begin
         taken_q   <= 1'b0;
         grant_vld <= 1'b0;
         no_winner <= 1'b0;
         grant_idx <= '0;
      end else if (!taken_q) begin
         taken_q   <= 1'b1;
         grant_vld <= any;
         no_winner <= !any;
         grant_idx <= any ? idx_in : '0;
      end
   end
endmodule

// File: rtl/msgarb.sv
module msgarb #(
   parameter int N   = 3,
   parameter int IDW = 3,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1,
   localparam int KW   = IDW + 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            win_open,
   input  logic [N-1:0]    node_vld,
   input  logic [N*IDW-1:0] node_id,
   input  logic [N-1:0]    node_rtr,
   input  logic [N*2-1:0]  node_err,
   output logic            grant_vld,
   output logic [IDXW-1:0] grant_idx,
   output logic            no_winner
);
   generate
      if (N < 2) begin : g_bad_n
         $error("msgarb: N must be at least 2");
      end
      if (IDW < 1) begin : g_bad_idw
         $error("msgarb: IDW must be at least 1");
      end
   endgenerate

   logic [N-1:0]    elig;
   logic [N*KW-1:0] keys;
   logic            any;
   logic [IDXW-1:0] pick_idx;

   genvar n;
   generate
      for (n = 0; n < N; n++) begin : g_node
         msgarb_elig #(.IDW(IDW)) u_elig (
            .vld  (node_vld[n]),
            .id   (node_id[n*IDW +: IDW]),
            .rtr  (node_rtr[n]),
            .err  (node_err[n*2 +: 2]),
            .elig (elig[n]),
            .key  (keys[n*KW +: KW])
         );
      end
   endgenerate

   msgarb_pick #(.N(N), .KW(KW), .IDXW(IDXW)) u_pick (
      .elig (elig),
      .keys (keys),
      .any  (any),
      .idx  (pick_idx)
   );

   msgarb_hold #(.IDXW(IDXW)) u_hold (
      .clk       (clk),
      .rst       (rst),
      .win_open  (win_open),
      .any       (any),
      .idx_in    (pick_idx),
      .grant_vld (grant_vld),
      .grant_idx (grant_idx),
      .no_winner (no_winner)
   );
endmodule

// File: rtl/msgarb_chk.sv
module msgarb_chk #(
   parameter int N   = 3,
   parameter int IDW = 3,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input logic            clk,
   input logic            rst,
   input logic            win_open,
   input logic [N-1:0]    node_vld,
   input logic [N*IDW-1:0] node_id,
   input logic [N-1:0]    node_rtr,
   input logic [N*2-1:0]  node_err,
   input logic            grant_vld,
   input logic [IDXW-1:0] grant_idx,
   input logic            no_winner
);
   // Copies of the inputs seen at the previous edge, plus a marker for an opening edge.
   logic [N-1:0]     vld_q;
   logic [N*IDW-1:0] id_q;
   logic [N*2-1:0]   err_q;
   logic             open_edge_q;
   logic             any_elig_q;
   logic             any_active_q;

   always_ff @(posedge clk) begin
      vld_q       <= node_vld;
      id_q        <= node_id;
      err_q       <= node_err;
      open_edge_q <= !rst && win_open && !(grant_vld || no_winner);
   end

   always_comb begin
      any_elig_q   = 1'b0;
      any_active_q = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (vld_q[k] && (id_q[k*IDW +: IDW] != {IDW{1'b1}}) && !err_q[k*2+1]) begin
            any_elig_q = 1'b1;
            if (err_q[k*2 +: 2] == 2'd0) any_active_q = 1'b1;
         end
      end
   end

   a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(grant_vld && no_winner));

   a_r4_idle_window: assert property (@(posedge clk) disable iff (rst)
      open_edge_q |-> (no_winner == !any_elig_q));

   a_r3_r7_contender: assert property (@(posedge clk) disable iff (rst)
      (open_edge_q && grant_vld) |->
         (vld_q[grant_idx] && (id_q[grant_idx*IDW +: IDW] != {IDW{1'b1}})
          && !err_q[grant_idx*2+1]));

   a_r6_active_first: assert property (@(posedge clk) disable iff (rst)
      (open_edge_q && grant_vld && (err_q[grant_idx*2 +: 2] == 2'd1)) |-> !any_active_q);

   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (grant_vld && $past(grant_vld)) |-> $stable(grant_idx));

   a_r10_close: assert property (@(posedge clk) disable iff (rst)
      !win_open |=> (!grant_vld && !no_winner && grant_idx == '0));
endmodule

bind msgarb msgarb_chk #(.N(N), .IDW(IDW)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .win_open  (win_open),
   .node_vld  (node_vld),
   .node_id   (node_id),
   .node_rtr  (node_rtr),
   .node_err  (node_err),
   .grant_vld (grant_vld),
   .grant_idx (grant_idx),
   .no_winner (no_winner)
);

// File: tb/msgarb_test.sv
module msgarb_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       win_open = 1'b0;
   logic [2:0] node_vld = '0;
   logic [8:0] node_id  = '0;
   logic [2:0] node_rtr = '0;
   logic [5:0] node_err = '0;
   logic       grant_vld;
   logic [1:0] grant_idx;
   logic       no_winner;

   int compared = 0;
   int mismatched = 0;

   always #5 clk = ~clk;

   msgarb #(.N(3), .IDW(3)) uut (
      .clk(clk), .rst(rst), .win_open(win_open),
      .node_vld(node_vld), .node_id(node_id), .node_rtr(node_rtr), .node_err(node_err),
      .grant_vld(grant_vld), .grant_idx(grant_idx), .no_winner(no_winner)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Packed view of the outputs: vld*8 + none*4 + idx.
   function automatic int outs();
      return int'(grant_vld) * 8 + int'(no_winner) * 4 + int'(grant_idx);
   endfunction

   // Ranking from the requirements: lower score wins, strict compare keeps lower index.
   task automatic model(input logic [2:0] v, input logic [8:0] ids, input logic [2:0] r,
                        input logic [5:0] e, output bit none, output int widx);
      int best;
      none = 1'b1;
      widx = 0;
      best = 0;
      for (int j = 0; j < 3; j++) begin
         int id, st, sc;
         id = int'(ids[j*3 +: 3]);
         st = int'(e[j*2 +: 2]);
         if (v[j] && id != 7 && st < 2) begin
            sc = (st == 1 ? 32 : 0) + (r[j] ? 0 : 16) + id;
            if (none || sc < best) begin
               best = sc;
               widx = j;
               none = 1'b0;
            end
         end
      end
   endtask

   // Entered at a falling edge; spans three clock cycles and leaves at a falling edge.
   task automatic trial(input logic [2:0] v, input logic [8:0] ids, input logic [2:0] r,
                        input logic [5:0] e, input bit exp_none, input int exp_idx,
                        input string req);
      int exp_o, tgt;
      exp_o = exp_none ? 4 : (8 + exp_idx);
      node_vld = v; node_id = ids; node_rtr = r; node_err = e;
      win_open = 1'b1;
      @(negedge clk);
      check(outs() == exp_o, req, outs(), exp_o);
      // Swap to a contender set that would pick another node (R9).
      tgt = exp_none ? 0 : (exp_idx + 1) % 3;
      node_vld = 3'b000; node_id = '0; node_rtr = '0; node_err = '0;
      node_vld[tgt] = 1'b1; node_rtr[tgt] = 1'b1;
      @(negedge clk);
      check(outs() == exp_o, "R9 hold", outs(), exp_o);
      win_open = 1'b0;
      @(negedge clk);
      check(outs() == 0, "R10 close", outs(), 0);
   endtask

   task automatic sweep_state(input int s, output logic vb, output logic [2:0] idv,
                              output logic rb, output logic [1:0] eb);
      if (s == 32) begin
         vb = 1'b0; idv = 3'd0; rb = 1'b0; eb = 2'd0;
      end else begin
         vb = 1'b1;
         case (s % 4)
            0: idv = 3'd0;
            1: idv = 3'd3;
            2: idv = 3'd5;
            default: idv = 3'd7;
         endcase
         rb = 1'((s / 4) % 2);
         eb = 2'((s / 8) % 4);
      end
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      bit nn;
      int wi;
      // R1: reset holds outputs low even with the window open.
      win_open = 1'b1;
      node_vld = 3'b111;
      repeat (3) @(negedge clk);
      check(outs() == 0, "R1 reset", outs(), 0);
      win_open = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check(outs() == 0, "R1 after reset", outs(), 0);

      // Directed cases: {node2,node1,node0} packing.
      trial(3'b111, {3'd6, 3'd3, 3'd5}, 3'b000, 6'b000000, 0, 1, "R2 lowest id");
      trial(3'b101, {3'd6, 3'd0, 3'd7}, 3'b000, 6'b000000, 0, 2, "R3 idle id and invalid");
      trial(3'b111, {3'd7, 3'd7, 3'd7}, 3'b111, 6'b000000, 1, 0, "R4 no winner");
      trial(3'b011, {3'd0, 3'd6, 3'd0}, 3'b010, 6'b000000, 0, 1, "R5 remote first");
      trial(3'b101, {3'd6, 3'd0, 3'd0}, 3'b001, 6'b000001, 0, 2, "R6 active first");
      trial(3'b111, {3'd5, 3'd0, 3'd0}, 3'b011, 6'b011110, 0, 2, "R7 bus-off excluded");
      trial(3'b111, {3'd0, 3'd0, 3'd0}, 3'b111, 6'b101010, 1, 0, "R7 all off");
      trial(3'b111, {3'd4, 3'd4, 3'd4}, 3'b000, 6'b000000, 0, 0, "R8 three-way tie");
      trial(3'b110, {3'd2, 3'd2, 3'd0}, 3'b110, 6'b010100, 0, 1, "R8 tie upper pair");

      // Near-exhaustive sweep over 33 states per node.
      for (int a = 0; a < 33; a++) begin
         for (int b = 0; b < 33; b++) begin
            for (int c = 0; c < 33; c++) begin
               logic [2:0] v, r;
               logic [8:0] ids;
               logic [5:0] e;
               sweep_state(a, v[0], ids[2:0], r[0], e[1:0]);
               sweep_state(b, v[1], ids[5:3], r[1], e[3:2]);
               sweep_state(c, v[2], ids[8:6], r[2], e[5:4]);
               model(v, ids, r, e, nn, wi);
               trial(v, ids, r, e, nn, wi, "R2 R3 R4 R5 R6 R7 R8 sweep");
            end
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule